// File: doc/BRIEF.md
# Duplex-Aware FIFO DMA Request Generator

This block decides when a MAC's bus master should move data into the transmit FIFO and out of the receive FIFO. It compares the FIFO levels against a two-bit watermark setting for each direction and drives one registered request per direction.

The duplex mode changes how the first 64 bytes of a frame are handled. In half duplex a collision can occur while those bytes are on the wire. On transmit, 64 bytes of FIFO space stay reserved until 512 bits of the frame have gone out, so a retry can replay them. On receive, data is not handed to the bus until 64 bytes of the frame have arrived, which lets runt fragments be discarded inside the FIFO.

In full duplex both safeguards are switched off. A runt-accept setting in half duplex switches off the receive safeguard alone. The FIFO storage, the bus engine and the frame parser are outside this block and supply its level and count inputs.

Top module: `dma_req_gen`

## Requirements
- R1: In half duplex, while a transmit frame is active and fewer than 512 bits of it have been sent, the usable transmit space is the free byte count minus 64, taken as 0 when the free count is below 64.
- R2: In half duplex, once 512 or more bits of the active frame have been sent, or when no frame is active, the usable transmit space is the whole free byte count.
- R3: In full duplex the usable transmit space is always the whole free byte count, whatever the frame activity and bit count.
- R4: The transmit watermark select maps 0, 1, 2 and 3 to 16, 64, 128 and 256 bytes. The transmit request condition is true when the usable space is greater than or equal to that threshold.
- R5: The receive watermark select maps 0, 1, 2 and 3 to 16, 64, 128 and 128 bytes. The receive fill condition is true when the FIFO fill count is greater than or equal to that threshold.
- R6: In half duplex with runt-accept clear, the receive request condition is true only when the current frame's received byte count is 64 or more and either the fill condition holds or the valid-frame strobe is high.
- R7: In full duplex the receive request condition is true when the fill condition holds or the valid-frame strobe is high, regardless of the frame's byte count.
- R8: In half duplex with runt-accept set, the receive request condition is the same as in full duplex (R7).
- R9: Each request output is registered. It equals its condition as sampled at the previous clock edge, so it rises one cycle after the condition becomes true and falls one cycle after the condition becomes false.
- R10: While reset is asserted, both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 selects full-duplex mode |
| runt_accept | input | 1 | In half duplex, 1 lifts the receive 64-byte gate |
| tx_wm_sel | input | 2 | Transmit watermark select |
| tx_free_bytes | input | LVL_W (10) | Free bytes in the transmit FIFO |
| tx_frame_active | input | 1 | A transmit frame is on the wire |
| tx_bits_sent | input | BIT_W (12) | Bits sent of the current transmit frame |
| rx_wm_sel | input | 2 | Receive watermark select |
| rx_fill_bytes | input | LVL_W (10) | Bytes held in the receive FIFO |
| rx_frame_bytes | input | CNT_W (11) | Bytes received of the current receive frame |
| rx_frame_valid | input | 1 | Strobe: a complete valid receive frame was detected |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that every level and count input is held for at least one full clock cycle. They also assume the counts never exceed their port widths, so each property's antecedent is still true at the edge whose register result it checks. The bench changes inputs only on the falling edge, one setting per clock. It sweeps every mode, every watermark select and a set of levels and counts placed on each side of every threshold and of the 64-byte and 512-bit limits, all kept within the port ranges.

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int LVL_W         = 10,
  parameter int BIT_W         = 12,
  parameter int CNT_W         = 11,
  parameter int PROTECT_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_duplex,
  input  logic             runt_accept,
  input  logic [1:0]       tx_wm_sel,
  input  logic [LVL_W-1:0] tx_free_bytes,
  input  logic             tx_frame_active,
  input  logic [BIT_W-1:0] tx_bits_sent,
  input  logic [1:0]       rx_wm_sel,
  input  logic [LVL_W-1:0] rx_fill_bytes,
  input  logic [CNT_W-1:0] rx_frame_bytes,
  input  logic             rx_frame_valid,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);

  localparam logic [BIT_W-1:0] GUARD_BITS  = BIT_W'(PROTECT_BYTES * 8);
  localparam logic [LVL_W-1:0] GUARD_LVL   = LVL_W'(PROTECT_BYTES);
  localparam logic [CNT_W-1:0] GUARD_CNT   = CNT_W'(PROTECT_BYTES);

  logic [LVL_W-1:0] tx_thresh, rx_thresh, tx_usable;
  logic             tx_guard, rx_gate_open, rx_fill_ok;
  logic             tx_cond, rx_cond;

  always_comb begin
    unique case (tx_wm_sel)
      2'd0:    tx_thresh = LVL_W'(16);
      2'd1:    tx_thresh = LVL_W'(64);
      2'd2:    tx_thresh = LVL_W'(128);
      default: tx_thresh = LVL_W'(256);
    endcase
    unique case (rx_wm_sel)
      2'd0:    rx_thresh = LVL_W'(16);
      2'd1:    rx_thresh = LVL_W'(64);
      default: rx_thresh = LVL_W'(128);
    endcase
  end

  assign tx_guard  = !full_duplex && tx_frame_active && (tx_bits_sent < GUARD_BITS);
  assign tx_usable = !tx_guard ? tx_free_bytes :
                     (tx_free_bytes >= GUARD_LVL) ? tx_free_bytes - GUARD_LVL : '0;
  assign tx_cond   = tx_usable >= tx_thresh;

  assign rx_gate_open = full_duplex || runt_accept || (rx_frame_bytes >= GUARD_CNT);
  assign rx_fill_ok   = rx_fill_bytes >= rx_thresh;
  assign rx_cond      = rx_gate_open && (rx_fill_ok || rx_frame_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_dma_req <= 1'b0;
      rx_dma_req <= 1'b0;
    end else begin
      tx_dma_req <= tx_cond;
      rx_dma_req <= rx_cond;
    end
  end

  // R1: reserved space plus the smallest watermark is not available
  p_tx_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && tx_frame_active && tx_bits_sent < GUARD_BITS &&
     tx_free_bytes < GUARD_LVL + LVL_W'(16)) |=> !tx_dma_req);

  // R3: full duplex with room above the largest watermark always requests
  p_tx_fd_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && tx_free_bytes >= LVL_W'(256)) |=> tx_dma_req);

  // R6: short frame in half duplex without runt-accept never requests
  p_rx_runt_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && !runt_accept && rx_frame_bytes < GUARD_CNT) |=> !rx_dma_req);

  // R7: a valid frame in an early mode always requests
  p_rx_early_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_duplex || runt_accept) && rx_frame_valid) |=> rx_dma_req);

  // R5: below the smallest watermark and no frame strobe, no receive request
  p_rx_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill_bytes < LVL_W'(16) && !rx_frame_valid) |=> !rx_dma_req);

endmodule

// File: tb/dma_req_gen_tb.sv
module dma_req_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 1'b0, runt_accept = 1'b0;
  logic [1:0] tx_wm_sel = '0, rx_wm_sel = '0;
  logic [9:0] tx_free_bytes = '0, rx_fill_bytes = '0;
  logic tx_frame_active = 1'b0, rx_frame_valid = 1'b0;
  logic [11:0] tx_bits_sent = '0;
  logic [10:0] rx_frame_bytes = '0;
  logic tx_dma_req, rx_dma_req;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_req_gen u_dut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .runt_accept(runt_accept),
    .tx_wm_sel(tx_wm_sel), .tx_free_bytes(tx_free_bytes), .tx_frame_active(tx_frame_active),
    .tx_bits_sent(tx_bits_sent), .rx_wm_sel(rx_wm_sel), .rx_fill_bytes(rx_fill_bytes),
    .rx_frame_bytes(rx_frame_bytes), .rx_frame_valid(rx_frame_valid),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  int lvls[16] = '{0, 15, 16, 63, 64, 79, 80, 127, 128, 191, 192, 255, 256, 319, 320, 1000};
  int bits[3]  = '{0, 511, 512};
  int fcnt[4]  = '{0, 63, 64, 200};

  function automatic bit exp_tx(int fd, int act, int b, int sel, int fr);
    int thr, use_b;
    thr = (sel == 0) ? 16 : (sel == 1) ? 64 : (sel == 2) ? 128 : 256;
    use_b = (fd == 0 && act == 1 && b < 512) ? ((fr >= 64) ? fr - 64 : 0) : fr;
    return use_b >= thr;
  endfunction

  function automatic bit exp_rx(int fd, int ra, int sel, int fl, int fb, int v);
    int thr;
    thr = (sel == 0) ? 16 : (sel == 1) ? 64 : 128;
    if (fd == 0 && ra == 0 && fb < 64) return 1'b0;
    return (fl >= thr) || (v == 1);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset holds both requests low even with conditions true
    full_duplex = 1'b1; tx_free_bytes = 10'd1000; rx_frame_valid = 1'b1;
    step(); step();
    check("R10 tx", tx_dma_req, 1'b0);
    check("R10 rx", rx_dma_req, 1'b0);
    rst_n = 1'b1; rx_frame_valid = 1'b0; full_duplex = 1'b0; tx_free_bytes = '0;
    step();

    // Transmit sweep: R1 R2 R3 R4
    for (int fd = 0; fd < 2; fd++)
      for (int act = 0; act < 2; act++)
        for (int bi = 0; bi < 3; bi++)
          for (int sel = 0; sel < 4; sel++)
            for (int li = 0; li < 16; li++) begin
              full_duplex = fd[0]; tx_frame_active = act[0];
              tx_bits_sent = 12'(bits[bi]); tx_wm_sel = 2'(sel);
              tx_free_bytes = 10'(lvls[li]);
              step();
              if (fd == 1) check("R3,R4", tx_dma_req, exp_tx(fd, act, bits[bi], sel, lvls[li]));
              else if (act == 1 && bits[bi] < 512)
                check("R1,R4", tx_dma_req, exp_tx(fd, act, bits[bi], sel, lvls[li]));
              else check("R2,R4", tx_dma_req, exp_tx(fd, act, bits[bi], sel, lvls[li]));
            end

    // Receive sweep: R5 R6 R7 R8
    for (int fd = 0; fd < 2; fd++)
      for (int ra = 0; ra < 2; ra++)
        for (int sel = 0; sel < 4; sel++)
          for (int li = 0; li < 16; li++)
            for (int fi = 0; fi < 4; fi++)
              for (int v = 0; v < 2; v++) begin
                full_duplex = fd[0]; runt_accept = ra[0]; rx_wm_sel = 2'(sel);
                rx_fill_bytes = 10'(lvls[li]); rx_frame_bytes = 11'(fcnt[fi]);
                rx_frame_valid = v[0];
                step();
                if (fd == 1) check("R7,R5", rx_dma_req, exp_rx(fd, ra, sel, lvls[li], fcnt[fi], v));
                else if (ra == 1) check("R8,R5", rx_dma_req, exp_rx(fd, ra, sel, lvls[li], fcnt[fi], v));
                else check("R6,R5", rx_dma_req, exp_rx(fd, ra, sel, lvls[li], fcnt[fi], v));
              end

    // R9: request follows the condition with one cycle of latency
    full_duplex = 1'b0; runt_accept = 1'b0; rx_wm_sel = 2'd0;
    rx_fill_bytes = 10'd100; rx_frame_bytes = 11'd100; rx_frame_valid = 1'b0;
    tx_frame_active = 1'b0; tx_wm_sel = 2'd0; tx_free_bytes = 10'd100;
    step();
    check("R9 rx high", rx_dma_req, 1'b1);
    check("R9 tx high", tx_dma_req, 1'b1);
    rx_fill_bytes = 10'd0; tx_free_bytes = 10'd0;
    #1;
    check("R9 rx held before edge", rx_dma_req, 1'b1);
    check("R9 tx held before edge", tx_dma_req, 1'b1);
    step();
    check("R9 rx drop", rx_dma_req, 1'b0);
    check("R9 tx drop", tx_dma_req, 1'b0);

    // R9: one-cycle valid strobe gives a one-cycle request
    runt_accept = 1'b1; rx_frame_bytes = 11'd10; rx_frame_valid = 1'b1;
    step();
    check("R9 strobe high", rx_dma_req, 1'b1);
    rx_frame_valid = 1'b0;
    step();
    check("R9 strobe drop", rx_dma_req, 1'b0);

    // R10: reset reasserted clears a live request
    rx_frame_valid = 1'b1; tx_free_bytes = 10'd500;
    step();
    check("R10 pre rx", rx_dma_req, 1'b1);
    rst_n = 1'b0;
    step();
    check("R10 rx", rx_dma_req, 1'b0);
    check("R10 tx", tx_dma_req, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule